// File: doc/BRIEF.md
# Byte-Serial 4:2:2 Stream Demultiplexer with Sync Recovery

This block sits at the input of a slave-mode video encoder. One byte arrives per clock on an 8-bit bus. During active video the bytes repeat in four-byte groups: a blue-difference chroma byte, a luma byte, a red-difference chroma byte, then a second luma byte. Luma therefore runs at half the byte rate and each chroma component at a quarter. The block separates the bytes into a luma stream and a chroma stream, and each stream has its own valid strobe. The chroma stream also carries a flag that marks red-difference samples.

Line and frame timing can come from two sources. The first is the timing reference codes embedded in the stream: a three-byte preamble followed by a status byte that carries field, vertical-blanking and start/end-of-active flags, together with protection bits. The second is a pair of external horizontal and vertical sync pins. A select input chooses between the two sources. Separately, the block watches for ancillary packets whose identifier byte matches a programmed value. When the ancillary option is enabled, it reports the packet's field count in place of the field flag taken from the embedded codes.

Top module: `vid_stream_demux`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `y_valid`, `c_valid`, `hsync`, `vsync` and `field_id` are all 0.
- R2: In embedded mode (`ext_sync_sel`=0), a status byte that directly follows the bytes 0xFF, 0x00, 0x00 and has valid protection is decoded as follows: bit 6 is the field F, bit 5 is vertical blanking V, and bit 4 is H (0 = start of active, 1 = end of active). On the next clock edge, `hsync` takes H and `vsync` takes V.
- R3: A status byte is valid only when bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}. An invalid status byte leaves `hsync`, `vsync`, `field_id` and the sample output unchanged.
- R4: After a valid start-of-active code with V=0, the bytes that follow are emitted in the order Cb, Y, Cr, Y, repeating. Each byte appears one clock after it enters the block: a luma byte on `y_data` with `y_valid`=1, and a chroma byte on `c_data` with `c_valid`=1 and `c_is_cr`=1 for Cr and 0 for Cb.
- R5: Every valid start-of-active code resets the byte phase, so the first byte after it is always treated as Cb, whatever the length of the line before.
- R6: In embedded mode, a 0xFF byte ends the active window. No byte is emitted again until the next valid start-of-active code with V=0. A start-of-active code with V=1 opens no window.
- R7: In external mode (`ext_sync_sel`=1), `hsync` and `vsync` equal `ext_hs` and `ext_vs` delayed by one clock. Embedded codes do not change them.
- R8: In external mode, a byte is emitted when `ext_hs` and `ext_vs` are both low as it enters. While `ext_hs` is high, the phase is held so that the next emitted byte is Cb.
- R9: An ancillary packet is the bytes 0x00, 0xFF, 0xFF, then an ID byte, then a payload byte whose bits 2..0 are the field count. It is accepted only if the ID byte equals `anc_id_cfg` and `anc_id_cfg` has an odd number of 1 bits.
- R10: When `anc_en`=1, `field_id` shows the last accepted field count, and it changes one clock after the payload byte. When `anc_en`=0, packets are not captured and `field_id` is {00, F}, where 000 means field 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Multiplexed input byte |
| ext_sync_sel | input | 1 | 1 = use external sync pins, 0 = use embedded codes |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical sync |
| anc_en | input | 1 | Take the field count from ancillary packets |
| anc_id_cfg | input | 8 | Expected ancillary ID: bits 7..1 ID, bit 0 odd parity |
| y_data | output | 8 | Luma sample |
| y_valid | output | 1 | Luma sample strobe |
| c_data | output | 8 | Chroma sample |
| c_valid | output | 1 | Chroma sample strobe |
| c_is_cr | output | 1 | Chroma sample is Cr (1) or Cb (0) |
| hsync | output | 1 | Horizontal blanking/sync |
| vsync | output | 1 | Vertical blanking/sync |
| field_id | output | 3 | Field identifier, 000 = field 1 |

## Verification
The assertions assume that 0xFF appears in active video only as the first byte of a timing code. They also assume that the select and ancillary configuration inputs change only between lines, not while a packet is in flight. The stimulus honours both. Active bytes are drawn from 0x01 to 0xFE. Blanking uses 0x10 and 0x80. Mode and configuration changes are made only between complete line sequences.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int BYTE_W = 8;
  localparam int FID_W  = 3;
  localparam int PRE_N  = 3;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tref_t;

  // protection nibble expected for a given F, V, H
  function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic xy_intact(input logic [7:0] xy);
    return xy[7] && (xy[3:0] == prot_bits(xy[6], xy[5], xy[4]));
  endfunction

  function automatic tref_t xy_fields(input logic [7:0] xy);
    return '{f: xy[6], v: xy[5], h: xy[4]};
  endfunction

  function automatic logic id_parity_odd(input logic [7:0] id);
    return ^id;
  endfunction
endpackage

// File: rtl/vsd_trs_detect.sv
module vsd_trs_detect
  import vsd_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         code_seen,
  output logic         code_good,
  output tref_t        code_ref
);
  localparam int HIST = PRE_N;
  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] ZEROS = '0;

  // hist[0] holds the most recent byte
  logic [HIST-1:0][W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HIST-2:0], din};
  end

  assign code_seen = (hist[2] == ONES) && (hist[1] == ZEROS) && (hist[0] == ZEROS);
  assign code_good = code_seen && xy_intact(din[7:0]);
  assign code_ref  = xy_fields(din[7:0]);

  assert_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_seen |-> ($past(din, 3) == ONES && $past(din, 2) == ZEROS && $past(din, 1) == ZEROS));
endmodule

// File: rtl/vsd_sample_split.sv
module vsd_sample_split
  import vsd_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         emit,
  input  logic         ph_clr,
  output logic [W-1:0] y_data,
  output logic         y_valid,
  output logic [W-1:0] c_data,
  output logic         c_valid,
  output logic         c_is_cr
);
  localparam int GROUP = 4;
  localparam int PH_W  = $clog2(GROUP);

  // phase 0 Cb, 1 Y, 2 Cr, 3 Y
  logic [PH_W-1:0] ph;
  logic            is_luma;

  assign is_luma = ph[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= '0;
      y_data  <= '0;
      y_valid <= 1'b0;
      c_data  <= '0;
      c_valid <= 1'b0;
      c_is_cr <= 1'b0;
    end else begin
      y_valid <= emit && is_luma;
      c_valid <= emit && !is_luma;
      if (emit && is_luma) y_data <= din;
      if (emit && !is_luma) begin
        c_data  <= din;
        c_is_cr <= ph[1];
      end
      if (ph_clr)    ph <= '0;
      else if (emit) ph <= ph + 1'b1;
    end
  end

  assert_one_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({y_valid, c_valid}));

  assert_chroma_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |=> !c_valid);

  assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_clr ##1 (emit && !ph_clr) |=> (c_valid && !c_is_cr));
endmodule

// File: rtl/vsd_anc_parser.sv
module vsd_anc_parser
  import vsd_pkg::*;
#(
  parameter int W   = BYTE_W,
  parameter int FCW = FID_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic           en,
  input  logic [W-1:0]   id_cfg,
  output logic [FCW-1:0] fc,
  output logic           fc_load
);
  localparam int HIST = PRE_N;
  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] ZEROS = '0;

  logic [HIST-1:0][W-1:0] hist;
  logic                   hdr_seen;
  logic                   id_hit;
  logic                   await_q;

  assign hdr_seen = (hist[2] == ZEROS) && (hist[1] == ONES) && (hist[0] == ONES);
  assign id_hit   = hdr_seen && (din == id_cfg) && id_parity_odd(id_cfg[7:0]);
  assign fc_load  = await_q && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      await_q <= 1'b0;
      fc      <= '0;
    end else begin
      hist    <= {hist[HIST-2:0], din};
      await_q <= id_hit;
      if (fc_load) fc <= din[FCW-1:0];
    end
  end

  assert_anc_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fc));

  assert_anc_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fc_load |=> fc == $past(din[FCW-1:0]));
endmodule

// File: rtl/vid_stream_demux.sv
module vid_stream_demux
  import vsd_pkg::*;
#(
  parameter int W   = BYTE_W,
  parameter int FCW = FID_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  input  logic           ext_sync_sel,
  input  logic           ext_hs,
  input  logic           ext_vs,
  input  logic           anc_en,
  input  logic [W-1:0]   anc_id_cfg,
  output logic [W-1:0]   y_data,
  output logic           y_valid,
  output logic [W-1:0]   c_data,
  output logic           c_valid,
  output logic           c_is_cr,
  output logic           hsync,
  output logic           vsync,
  output logic [FCW-1:0] field_id
);
  localparam logic [W-1:0] ONES = '1;

  logic           code_seen, code_good, sav_open;
  tref_t          code_ref, tref_q;
  logic           active_q, sel_q, hs_q, vs_q;
  logic           emit, ph_clr;
  logic [FCW-1:0] anc_fc;
  logic           anc_load;

  vsd_trs_detect #(.W(W)) u_trs (
    .clk(clk), .rst_n(rst_n), .din(din),
    .code_seen(code_seen), .code_good(code_good), .code_ref(code_ref)
  );

  assign sav_open = code_good && !code_ref.h && !code_ref.v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tref_q   <= '0;
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
    end else begin
      sel_q <= ext_sync_sel;
      hs_q  <= ext_hs;
      vs_q  <= ext_vs;
      if (code_good) begin
        tref_q   <= code_ref;
        active_q <= sav_open;
      end else if (din == ONES) begin
        active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (ext_sync_sel) begin
      emit   = !ext_hs && !ext_vs;
      ph_clr = ext_hs;
    end else begin
      emit   = active_q && (din != ONES);
      ph_clr = sav_open;
    end
  end

  vsd_sample_split #(.W(W)) u_split (
    .clk(clk), .rst_n(rst_n), .din(din), .emit(emit), .ph_clr(ph_clr),
    .y_data(y_data), .y_valid(y_valid), .c_data(c_data),
    .c_valid(c_valid), .c_is_cr(c_is_cr)
  );

  vsd_anc_parser #(.W(W), .FCW(FCW)) u_anc (
    .clk(clk), .rst_n(rst_n), .din(din), .en(anc_en), .id_cfg(anc_id_cfg),
    .fc(anc_fc), .fc_load(anc_load)
  );

  assign hsync    = sel_q ? hs_q : tref_q.h;
  assign vsync    = sel_q ? vs_q : tref_q.v;
  assign field_id = anc_en ? anc_fc : {{(FCW-1){1'b0}}, tref_q.f};

  assert_trs_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_good && !ext_sync_sel) |=> (hsync == $past(din[4]) && vsync == $past(din[5])));

  assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_seen && !code_good && !ext_sync_sel && !sel_q) |=> $stable({hsync, vsync}));

  assert_ext_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_sel |=> (hsync == $past(ext_hs) && vsync == $past(ext_vs)));

  assert_window_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sync_sel && !active_q && !code_good) |=> !(y_valid || c_valid));
endmodule

// File: tb/vid_stream_demux_bench.sv
module vid_stream_demux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic       ext_sync_sel = 1'b0, ext_hs = 1'b0, ext_vs = 1'b0, anc_en = 1'b0;
  logic [7:0] anc_id_cfg = 8'h00;
  logic [7:0] y_data, c_data;
  logic       y_valid, c_valid, c_is_cr, hsync, vsync;
  logic [2:0] field_id;

  always #2.5 clk = ~clk;

  vid_stream_demux u_vid_stream_demux (
    .clk(clk), .rst_n(rst_n), .din(din), .ext_sync_sel(ext_sync_sel),
    .ext_hs(ext_hs), .ext_vs(ext_vs), .anc_en(anc_en), .anc_id_cfg(anc_id_cfg),
    .y_data(y_data), .y_valid(y_valid), .c_data(c_data), .c_valid(c_valid),
    .c_is_cr(c_is_cr), .hsync(hsync), .vsync(vsync), .field_id(field_id)
  );

  int    nvec = 0, nfail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference state
  bit [7:0] m_hist [3];
  bit [7:0] a_hist [3];
  bit       m_act, m_f, m_v, m_h, m_sel, m_hs, m_vs, a_wait;
  bit [1:0] m_ph;
  bit [2:0] a_fc;
  bit       e_yv, e_cv, e_cr;
  bit [7:0] e_yd, e_cd;

  function automatic bit [7:0] mk_xy(input bit f, input bit v, input bit h);
    int sfv = int'(f) + int'(v);
    mk_xy = {1'b1, f, v, h,
             1'(((int'(v) + int'(h)) % 2)), 1'(((int'(f) + int'(h)) % 2)),
             1'((sfv % 2)), 1'(((sfv + int'(h)) % 2))};
  endfunction

  function automatic bit xy_ok(input bit [7:0] x);
    bit [7:0] ref_x = mk_xy(x[6], x[5], x[4]);
    return x[7] && (x[3:0] == ref_x[3:0]);
  endfunction

  function automatic bit odd_ones(input bit [7:0] x);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(x[i]);
    return (n % 2) == 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_hist[i] = 8'h00; a_hist[i] = 8'h00; end
    {m_act, m_f, m_v, m_h, m_sel, m_hs, m_vs, a_wait} = '0;
    m_ph = 0; a_fc = 0; {e_yv, e_cv, e_cr} = '0; e_yd = 0; e_cd = 0;
  endtask

  task automatic check_outputs();
    bit       ehs = m_sel ? m_hs : m_h;
    bit       evs = m_sel ? m_vs : m_v;
    bit [2:0] efid = anc_en ? a_fc : {2'b00, m_f};
    nvec++;
    if (y_valid !== e_yv || (e_yv && y_data !== e_yd) || c_valid !== e_cv ||
        (e_cv && (c_data !== e_cd || c_is_cr !== e_cr)) || hsync !== ehs ||
        vsync !== evs || field_id !== efid) begin
      nfail++;
      $display("FAIL %s: got yv=%0b y=%h cv=%0b c=%h cr=%0b hs=%0b vs=%0b fid=%0d exp yv=%0b y=%h cv=%0b c=%h cr=%0b hs=%0b vs=%0b fid=%0d",
               tag, y_valid, y_data, c_valid, c_data, c_is_cr, hsync, vsync, field_id,
               e_yv, e_yd, e_cv, e_cd, e_cr, ehs, evs, efid);
    end
  endtask

  task automatic step(input bit [7:0] d);
    bit seen = (m_hist[2] == 8'hFF) && (m_hist[1] == 8'h00) && (m_hist[0] == 8'h00);
    bit good = seen && xy_ok(d);
    bit sav  = good && !d[4] && !d[5];
    bit emit = ext_sync_sel ? (!ext_hs && !ext_vs) : (m_act && d != 8'hFF);
    bit hdr  = (a_hist[2] == 8'h00) && (a_hist[1] == 8'hFF) && (a_hist[0] == 8'hFF);
    e_yv = emit && m_ph[0];
    e_cv = emit && !m_ph[0];
    if (e_yv) e_yd = d;
    if (e_cv) begin e_cd = d; e_cr = m_ph[1]; end
    if (ext_sync_sel ? ext_hs : sav) m_ph = 0;
    else if (emit) m_ph = m_ph + 1;
    if (good) begin {m_f, m_v, m_h} = d[6:4]; m_act = sav; end
    else if (d == 8'hFF) m_act = 0;
    m_sel = ext_sync_sel; m_hs = ext_hs; m_vs = ext_vs;
    if (a_wait && anc_en) a_fc = d[2:0];
    a_wait = hdr && (d == anc_id_cfg) && odd_ones(anc_id_cfg);
    m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = d;
    a_hist[2] = a_hist[1]; a_hist[1] = a_hist[0]; a_hist[0] = d;
    din = d;
    @(posedge clk); #1;
    check_outputs();
  endtask

  task automatic send_code(input bit f, input bit v, input bit h, input bit [7:0] corrupt);
    step(8'hFF); step(8'h00); step(8'h00); step(mk_xy(f, v, h) ^ corrupt);
  endtask

  task automatic send_blank(input int n);
    for (int i = 0; i < n; i++) step(i[0] ? 8'h10 : 8'h80);
  endtask

  task automatic send_active(input int n);
    for (int i = 0; i < n; i++) step(8'($urandom_range(1, 254)));
  endtask

  task automatic send_anc(input bit [7:0] id, input bit [7:0] pay);
    step(8'h00); step(8'hFF); step(8'hFF); step(id); step(pay);
  endtask

  task automatic emb_line(input bit f, input bit v, input int n);
    send_code(f, v, 1'b1, 8'h00); send_blank(6);
    send_code(f, v, 1'b0, 8'h00); send_active(n);
  endtask

  initial begin
    void'($urandom(32'h5EED_0656));
    model_reset();
    // R1: outputs idle during reset and on the first edge after release
    repeat (3) @(posedge clk);
    #1; check_outputs();
    rst_n = 1'b1;
    @(posedge clk); #1; check_outputs();

    tag = "R2"; emb_line(1, 0, 12); emb_line(0, 1, 8); emb_line(0, 0, 16);
    tag = "R3"; // corrupted protection bit, cleared bit 7
    send_code(1, 1, 1, 8'h01); send_blank(3); send_code(1, 0, 0, 8'h08);
    send_active(6); send_code(1, 1, 0, 8'h80); send_active(4);
    tag = "R4"; emb_line(0, 0, 24);
    tag = "R5"; emb_line(0, 0, 5); emb_line(0, 0, 7); emb_line(1, 0, 9);
    tag = "R6"; emb_line(0, 1, 10);
    send_code(0, 0, 0, 8'h00); send_active(6); step(8'hFF); step(8'h40); step(8'h50);
    send_active(5);
    tag = "R7"; ext_sync_sel = 1; ext_hs = 1; send_code(1, 1, 1, 8'h00);
    ext_hs = 0; send_active(4); ext_vs = 1; send_active(3); ext_vs = 0;
    tag = "R8"; ext_hs = 1; send_blank(3); ext_hs = 0; send_active(11);
    ext_hs = 1; send_blank(2); ext_hs = 0; send_active(9); ext_sync_sel = 0;
    tag = "R9"; anc_en = 1; anc_id_cfg = 8'h02;
    send_anc(8'h02, 8'h05); send_blank(2); send_anc(8'h04, 8'h03); send_blank(2);
    anc_id_cfg = 8'h03; send_anc(8'h03, 8'h06); send_blank(2);
    anc_id_cfg = 8'hA1; send_anc(8'hA1, 8'h07); send_blank(2);
    tag = "R10"; anc_en = 0; send_anc(8'hA1, 8'h02); emb_line(1, 0, 4);
    anc_en = 1; send_blank(2); send_anc(8'hA1, 8'h00); send_blank(2); anc_en = 0;
    send_blank(2);

    tag = "R2";
    for (int ln = 0; ln < 40; ln++) begin
      int kind = $urandom_range(0, 9);
      if (kind == 0) begin
        ext_sync_sel = 1; ext_hs = 1; send_blank($urandom_range(1, 5));
        ext_hs = 0; ext_vs = ($urandom_range(0, 3) == 0); send_active($urandom_range(3, 20));
        ext_vs = 0; ext_sync_sel = 0;
      end else begin
        bit f = 1'($urandom_range(0, 1));
        bit v = ($urandom_range(0, 4) == 0);
        bit [7:0] cor = ($urandom_range(0, 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
        send_code(f, v, 1'b1, cor); send_blank($urandom_range(2, 8));
        if (kind == 1) begin anc_en = 1; send_anc(anc_id_cfg, 8'($urandom)); end
        send_code(f, v, 1'b0, 8'h00); send_active($urandom_range(1, 40)); anc_en = 0;
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule